// File: doc/BRIEF.md
# Shadow Store and Recall Sequencer

This block controls a memory in which every SRAM cell has a nonvolatile shadow cell. It decides when the SRAM image is saved into the shadow (a store) and when the shadow is copied back into the SRAM (a recall). It runs each operation through timed phases and reports the current phase as a code that the array logic decodes. It also drives a shared open-drain busy line and gates the host's read and write cycles.

A store can come from four places. The busy line can be pulled low by another agent. A decoded software store command can arrive as a pulse. The supply monitor can flag a power failure. A recall runs when the supply-good indication returns, or when a software recall pulse arrives. A write-tracking latch records whether the SRAM changed since the last store or recall. Stores requested by the line and by power failure are skipped while that latch is clear. A software store always runs.

The automatic store on power failure can be switched off or on by command. That choice lives in a working flag and in a nonvolatile copy. The copy is refreshed only by a manual store and is reloaded by every recall. All durations are parameters counted in clock cycles, and the array transfer is modelled as one whole-array step per phase.

Top module: `nv_shadow_seq`

## Requirements
- R1: After reset the phase is idle, `idle_o` is 1, automatic store is enabled, the busy line is neither pulled low nor driven high, and a recall is pending. Phase codes on `phase_o`: 0 idle, 1 delay window, 2 erase, 3 program, 4 release (driving high), 5 SRAM clear, 6 shadow load, 7 external hold.
- R2: While `pwr_ok_i` is 1 and a recall is pending, the block leaves idle at the next edge. It spends CLEAR_CYC cycles in phase 5 and LOAD_CYC cycles in phase 6, pulling the busy line low in both. It then drives the line high for HIGH_CYC cycles in phase 4 and returns to idle. A recall becomes pending whenever `pwr_ok_i` is 0.
- R3: `rd_allow_o` is 1 exactly when `pwr_ok_i` is 1 and the phase is 0 or 1. `wr_allow_o` is 1 exactly when `pwr_ok_i` is 1, the phase is 0 and `busy_pin_i` is 1.
- R4: The write latch is set by a host write accepted while `wr_allow_o` is 1. It is cleared at the end of every store and every recall. Writes offered while `wr_allow_o` is 0 leave it unchanged.
- R5: A low `busy_pin_i` seen in idle with the latch set starts a store. The store spends DELAY_CYC cycles in phase 1, ERASE_CYC in phase 2, PROG_CYC in phase 3 and HIGH_CYC in phase 4. The busy line is pulled low from phase 1 through phase 3.
- R6: A low `busy_pin_i` seen in idle with the latch clear moves to phase 7. There the line is not pulled, reads and writes are blocked, and the block returns to idle one edge after the line reads high.
- R7: A `sw_store_i` pulse in idle starts the same store sequence as R5 whatever the latch holds. A `sw_recall_i` pulse in idle runs phase 1, then phases 5 and 6, and then returns straight to idle without pulling or driving the line.
- R8: A rising edge on `pwr_fail_i` seen in idle starts a store only when automatic store is enabled and the latch is set. Otherwise the phase stays 0.
- R9: Power-fail edges during a store are absorbed. After that store the block stays idle.
- R10: `sw_auto_dis_i` and `sw_auto_ena_i` pulses in idle change `auto_store_en_o` at the next edge. The nonvolatile copy takes the working flag at the end of phase 3 of a line-requested or software store only. Every recall reloads the working flag from the copy, which resets to enabled.
- R11: The line is never pulled low and driven high at once. Every release of the pull-low is followed at once by the high drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply above switch threshold |
| pwr_fail_i | input | 1 | Power-failure indication, rising edge requests a store |
| busy_pin_i | input | 1 | Sensed level of the open-drain busy line |
| sw_store_i | input | 1 | Decoded software store command pulse |
| sw_recall_i | input | 1 | Decoded software recall command pulse |
| sw_auto_dis_i | input | 1 | Command pulse clearing automatic store |
| sw_auto_ena_i | input | 1 | Command pulse setting automatic store |
| host_wr_i | input | 1 | Host SRAM write request |
| busy_pull_low_o | output | 1 | Enables the open-drain pull-down on the busy line |
| busy_drive_high_o | output | 1 | Drives the busy line high for the release phase |
| rd_allow_o | output | 1 | Host reads permitted |
| wr_allow_o | output | 1 | Host writes permitted |
| phase_o | output | 3 | Current phase code |
| auto_store_en_o | output | 1 | Automatic store enable flag |
| idle_o | output | 1 | Sequencer idle |

## Verification
A request sampled at one rising edge shows on `phase_o` one edge later, so the bench checks the phase at the following falling edge. From then on it counts falling edges spent in each phase and compares them with the duration parameters. The access gates follow the phase and the sensed line in the same cycle, so they are read one time step after the bench changes the line, without waiting for a clock. Effects that are not visible directly are observed at the next command. The state of the write latch is judged by whether a later line request leads to phase 1 or phase 7. The nonvolatile enable copy is judged by `auto_store_en_o` right after a recall.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DELAY   = 3'd1,
    PH_ERASE   = 3'd2,
    PH_PROG    = 3'd3,
    PH_RELEASE = 3'd4,
    PH_CLEAR   = 3'd5,
    PH_LOAD    = 3'd6,
    PH_HOLD    = 3'd7
  } phase_t;
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/nvs_flags.sv
module nvs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic pwr_fail,
  input  logic wr_accept,
  input  logic cmd_ok,
  input  logic auto_dis,
  input  logic auto_ena,
  input  logic rcl_start,
  input  logic end_store_man,
  input  logic end_op,
  input  logic end_recall,
  output logic wlatch,
  output logic auto_en,
  output logic rec_pend,
  output logic pf_rise
);
  logic wlatch_d, auto_d, nv_auto_q, nv_auto_d, rec_d, pf_q;

  always_comb begin
    wlatch_d = wlatch;
    if (end_op)         wlatch_d = 1'b0;
    else if (wr_accept) wlatch_d = 1'b1;

    auto_d = auto_en;
    if (end_recall)                auto_d = nv_auto_q;
    else if (cmd_ok && auto_dis)   auto_d = 1'b0;
    else if (cmd_ok && auto_ena)   auto_d = 1'b1;

    nv_auto_d = nv_auto_q;
    if (end_store_man) nv_auto_d = auto_en;

    rec_d = rec_pend;
    if (!pwr_ok)        rec_d = 1'b1;
    else if (rcl_start) rec_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlatch    <= 1'b0;
      auto_en   <= 1'b1;
      nv_auto_q <= 1'b1;
      rec_pend  <= 1'b1;
      pf_q      <= 1'b0;
    end else begin
      wlatch    <= wlatch_d;
      auto_en   <= auto_d;
      nv_auto_q <= nv_auto_d;
      rec_pend  <= rec_d;
      pf_q      <= pwr_fail;
    end
  end

  assign pf_rise = pwr_fail & ~pf_q;
endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
  import nvs_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 6,
  parameter int CLEAR_CYC = 3,
  parameter int LOAD_CYC  = 5,
  parameter int HIGH_CYC  = 2,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          rec_pend,
  input  logic          busy_pin,
  input  logic          sw_store,
  input  logic          sw_recall,
  input  logic          pf_req,
  input  logic          wlatch,
  input  logic          tmr_done,
  output phase_t        phase,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          pull_low,
  output logic          drive_high,
  output logic          rcl_start,
  output logic          end_store,
  output logic          end_store_man,
  output logic          end_recall
);
  localparam logic [CW-1:0] L_DELAY = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] L_CLEAR = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] L_LOAD  = CW'(LOAD_CYC - 1);
  localparam logic [CW-1:0] L_HIGH  = CW'(HIGH_CYC - 1);

  phase_t state_q, state_d;
  logic   rcl_q, rcl_d, drv_q, drv_d, man_q, man_d;

  always_comb begin
    state_d = state_q;
    rcl_d   = rcl_q;
    drv_d   = drv_q;
    man_d   = man_q;
    unique case (state_q)
      PH_IDLE: begin
        if (pwr_ok) begin
          if (rec_pend) begin
            state_d = PH_CLEAR; rcl_d = 1'b1; drv_d = 1'b1; man_d = 1'b0;
          end else if (!busy_pin) begin
            if (wlatch) begin
              state_d = PH_DELAY; rcl_d = 1'b0; drv_d = 1'b1; man_d = 1'b1;
            end else begin
              state_d = PH_HOLD;
            end
          end else if (sw_store) begin
            state_d = PH_DELAY; rcl_d = 1'b0; drv_d = 1'b1; man_d = 1'b1;
          end else if (sw_recall) begin
            state_d = PH_DELAY; rcl_d = 1'b1; drv_d = 1'b0; man_d = 1'b0;
          end else if (pf_req && wlatch) begin
            state_d = PH_DELAY; rcl_d = 1'b0; drv_d = 1'b1; man_d = 1'b0;
          end
        end
      end
      PH_DELAY:   if (tmr_done) state_d = rcl_q ? PH_CLEAR : PH_ERASE;
      PH_ERASE:   if (tmr_done) state_d = PH_PROG;
      PH_PROG:    if (tmr_done) state_d = PH_RELEASE;
      PH_CLEAR:   if (tmr_done) state_d = PH_LOAD;
      PH_LOAD:    if (tmr_done) state_d = drv_q ? PH_RELEASE : PH_IDLE;
      PH_RELEASE: if (tmr_done) state_d = PH_IDLE;
      PH_HOLD:    if (busy_pin) state_d = PH_IDLE;
      default:    state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    tmr_val = '0;
    unique case (state_d)
      PH_DELAY:   tmr_val = L_DELAY;
      PH_ERASE:   tmr_val = L_ERASE;
      PH_PROG:    tmr_val = L_PROG;
      PH_CLEAR:   tmr_val = L_CLEAR;
      PH_LOAD:    tmr_val = L_LOAD;
      PH_RELEASE: tmr_val = L_HIGH;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      rcl_q   <= 1'b0;
      drv_q   <= 1'b0;
      man_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcl_q   <= rcl_d;
      drv_q   <= drv_d;
      man_q   <= man_d;
    end
  end

  assign phase         = state_q;
  assign tmr_load      = (state_d != state_q);
  assign pull_low      = drv_q & ((state_q == PH_DELAY) | (state_q == PH_ERASE) |
                                  (state_q == PH_PROG)  | (state_q == PH_CLEAR) |
                                  (state_q == PH_LOAD));
  assign drive_high    = (state_q == PH_RELEASE);
  assign rcl_start     = (state_d == PH_CLEAR) & (state_q != PH_CLEAR);
  assign end_store     = (state_q == PH_PROG) & tmr_done;
  assign end_store_man = end_store & man_q;
  assign end_recall    = (state_q == PH_LOAD) & tmr_done;
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nvs_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 6,
  parameter int CLEAR_CYC = 3,
  parameter int LOAD_CYC  = 5,
  parameter int HIGH_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok_i,
  input  logic       pwr_fail_i,
  input  logic       busy_pin_i,
  input  logic       sw_store_i,
  input  logic       sw_recall_i,
  input  logic       sw_auto_dis_i,
  input  logic       sw_auto_ena_i,
  input  logic       host_wr_i,
  output logic       busy_pull_low_o,
  output logic       busy_drive_high_o,
  output logic       rd_allow_o,
  output logic       wr_allow_o,
  output logic [2:0] phase_o,
  output logic       auto_store_en_o,
  output logic       idle_o
);
  localparam int M1   = (DELAY_CYC > ERASE_CYC) ? DELAY_CYC : ERASE_CYC;
  localparam int M2   = (PROG_CYC  > CLEAR_CYC) ? PROG_CYC  : CLEAR_CYC;
  localparam int M3   = (LOAD_CYC  > HIGH_CYC)  ? LOAD_CYC  : HIGH_CYC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(MAXD + 1);

  logic [1:0]    rs_q;
  logic          rst_int_n;
  phase_t        phase;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          rcl_start, end_store, end_store_man, end_recall;
  logic          wlatch, auto_en, rec_pend, pf_rise;
  logic          in_idle, cmd_ok, wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign in_idle   = (phase == PH_IDLE);
  assign cmd_ok    = in_idle & pwr_ok_i;
  assign wr_accept = host_wr_i & wr_allow_o;

  nvs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  nvs_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .pwr_ok        (pwr_ok_i),
    .pwr_fail      (pwr_fail_i),
    .wr_accept     (wr_accept),
    .cmd_ok        (cmd_ok),
    .auto_dis      (sw_auto_dis_i),
    .auto_ena      (sw_auto_ena_i),
    .rcl_start     (rcl_start),
    .end_store_man (end_store_man),
    .end_op        (end_store | end_recall),
    .end_recall    (end_recall),
    .wlatch        (wlatch),
    .auto_en       (auto_en),
    .rec_pend      (rec_pend),
    .pf_rise       (pf_rise)
  );

  nvs_fsm #(
    .DELAY_CYC (DELAY_CYC),
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .LOAD_CYC  (LOAD_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .pwr_ok        (pwr_ok_i),
    .rec_pend      (rec_pend),
    .busy_pin      (busy_pin_i),
    .sw_store      (sw_store_i),
    .sw_recall     (sw_recall_i),
    .pf_req        (pf_rise & auto_en),
    .wlatch        (wlatch),
    .tmr_done      (tmr_done),
    .phase         (phase),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .pull_low      (busy_pull_low_o),
    .drive_high    (busy_drive_high_o),
    .rcl_start     (rcl_start),
    .end_store     (end_store),
    .end_store_man (end_store_man),
    .end_recall    (end_recall)
  );

  assign rd_allow_o      = pwr_ok_i & (in_idle | (phase == PH_DELAY));
  assign wr_allow_o      = pwr_ok_i & in_idle & busy_pin_i;
  assign phase_o         = phase;
  assign auto_store_en_o = auto_en;
  assign idle_o          = in_idle;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_pin,
  input logic [2:0] phase,
  input logic       pull_low,
  input logic       drive_high,
  input logic       rd_ok,
  input logic       wr_ok
);
  // R11
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_low && drive_high));
  // R11
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low) |-> drive_high);
  // R3
  store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 || phase == 3'd3 || phase == 3'd5 || phase == 3'd6 || phase == 3'd7)
      |-> (!rd_ok && !wr_ok));
  // R5
  store_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 || phase == 3'd3) |-> pull_low);
  // R5
  erase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && $past(phase) != 3'd2) |-> $past(phase) == 3'd1);
  // R5
  erase_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 3'd2 && phase != 3'd2) |-> phase == 3'd3);
  // R2
  clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 3'd5 && phase != 3'd5) |-> phase == 3'd6);
  // R6
  hold_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |-> (!pull_low && !drive_high));
  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7 && busy_pin) |=> phase == 3'd0);
endmodule

bind nv_shadow_seq nvs_chk u_nvs_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .busy_pin   (busy_pin_i),
  .phase      (phase_o),
  .pull_low   (busy_pull_low_o),
  .drive_high (busy_drive_high_o),
  .rd_ok      (rd_allow_o),
  .wr_ok      (wr_allow_o)
);

// File: tb/nv_shadow_seq_tb.sv
`timescale 1ns/1ps
module nv_shadow_seq_tb;
  localparam int DLY = 4, ERS = 6, PRG = 6, CLR = 3, LDC = 5, HI = 2;

  logic clk, rst_n, pwr_ok, pwr_fail, sw_store, sw_recall, sw_dis, sw_ena, host_wr, ext_low;
  logic busy_pin, pull_low, drv_high, rd_ok, wr_ok, auto_en, idle;
  logic [2:0] phase;
  int n_run, n_fail;

  assign busy_pin = ~(pull_low | ext_low);

  nv_shadow_seq #(.DELAY_CYC(DLY), .ERASE_CYC(ERS), .PROG_CYC(PRG),
                  .CLEAR_CYC(CLR), .LOAD_CYC(LDC), .HIGH_CYC(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .pwr_fail_i(pwr_fail),
    .busy_pin_i(busy_pin), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .sw_auto_dis_i(sw_dis), .sw_auto_ena_i(sw_ena), .host_wr_i(host_wr),
    .busy_pull_low_o(pull_low), .busy_drive_high_o(drv_high),
    .rd_allow_o(rd_ok), .wr_allow_o(wr_ok), .phase_o(phase),
    .auto_store_en_o(auto_en), .idle_o(idle));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_ph(input int p, input string rq);
    int k = 0;
    while (int'(phase) != p && k < 300) begin k++; tick(); end
    chk(rq, int'(phase), p);
  endtask

  task automatic run_len(input int p, output int n);
    n = 0;
    while (int'(phase) == p && n < 500) begin n++; tick(); end
  endtask

  task automatic pulse_store();  sw_store = 1'b1;  tick(); sw_store = 1'b0;  endtask
  task automatic pulse_recall(); sw_recall = 1'b1; tick(); sw_recall = 1'b0; endtask
  task automatic pulse_pf();     pwr_fail = 1'b1;  tick(); pwr_fail = 1'b0;  endtask
  task automatic pulse_dis();    sw_dis = 1'b1;    tick(); sw_dis = 1'b0;    endtask
  task automatic pulse_ena();    sw_ena = 1'b1;    tick(); sw_ena = 1'b0;    endtask
  task automatic one_write();    host_wr = 1'b1;   tick(); host_wr = 1'b0;   endtask

  task automatic power_cycle();
    pwr_ok = 1'b0; tick(); tick();
    pwr_ok = 1'b1;
    wait_ph(5, "R2 recall after supply return");
    wait_ph(0, "R2 recall completes");
  endtask

  function automatic int exp_rd(input logic ok, input logic [2:0] ph);
    return int'(ok && (ph == 3'd0 || ph == 3'd1));
  endfunction
  function automatic int exp_wr(input logic ok, input logic [2:0] ph, input logic pin);
    return int'(ok && ph == 3'd0 && pin);
  endfunction

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int n;
    n_run = 0; n_fail = 0;
    rst_n = 0; pwr_ok = 0; pwr_fail = 0; sw_store = 0; sw_recall = 0;
    sw_dis = 0; sw_ena = 0; host_wr = 0; ext_low = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 phase idle", int'(phase), 0);
    chk("R1 idle flag", int'(idle), 1);
    chk("R1 auto enabled", int'(auto_en), 1);
    chk("R1 no pull", int'(pull_low), 0);
    chk("R1 no high drive", int'(drv_high), 0);
    chk("R3 rd blocked low supply", int'(rd_ok), 0);
    chk("R3 wr blocked low supply", int'(wr_ok), 0);

    // R2 power-up recall
    pwr_ok = 1'b1; tick();
    chk("R2 clear phase", int'(phase), 5);
    chk("R2 pull during clear", int'(pull_low), 1);
    run_len(5, n); chk("R2 clear length", n, CLR);
    chk("R2 load phase", int'(phase), 6);
    chk("R2 pull during load", int'(pull_low), 1);
    run_len(6, n); chk("R2 load length", n, LDC);
    chk("R2 release drive", int'(drv_high), 1);
    run_len(4, n); chk("R2 release length", n, HI);
    chk("R2 back to idle", int'(phase), 0);
    chk("R3 rd open idle", int'(rd_ok), 1);
    chk("R3 wr open idle", int'(wr_ok), 1);

    // R6 external hold with latch clear
    ext_low = 1'b1; #1;
    chk("R3 wr closed pin low", int'(wr_ok), 0);
    chk("R3 rd open pin low idle", int'(rd_ok), 1);
    tick();
    chk("R6 hold phase", int'(phase), 7);
    chk("R6 no pull in hold", int'(pull_low), 0);
    chk("R6 rd blocked", int'(rd_ok), 0);
    tick();
    chk("R6 still holding", int'(phase), 7);
    ext_low = 1'b0; tick();
    chk("R6 release to idle", int'(phase), 0);

    // R4 + R5 line store after a write
    one_write();
    ext_low = 1'b1; tick(); ext_low = 1'b0;
    chk("R5 delay phase", int'(phase), 1);
    chk("R5 pull in delay", int'(pull_low), 1);
    chk("R3 rd open in delay", int'(rd_ok), 1);
    chk("R3 wr closed in delay", int'(wr_ok), 0);
    host_wr = 1'b1;
    run_len(1, n); chk("R5 delay length", n, DLY);
    host_wr = 1'b0;
    chk("R5 erase phase", int'(phase), 2);
    run_len(2, n); chk("R5 erase length", n, ERS);
    chk("R5 program phase", int'(phase), 3);
    run_len(3, n); chk("R5 program length", n, PRG);
    chk("R11 high after pull", int'(drv_high), 1);
    chk("R11 pull released", int'(pull_low), 0);
    run_len(4, n); chk("R5 release length", n, HI);
    chk("R5 idle after store", int'(phase), 0);
    // R4 latch cleared, blocked write not recorded
    ext_low = 1'b1; tick(); ext_low = 1'b0;
    chk("R4 latch clear after store", int'(phase), 7);
    tick();
    chk("R6 hold ends", int'(phase), 0);

    // R7 software store without writes
    pulse_store();
    chk("R7 sw store starts", int'(phase), 1);
    wait_ph(2, "R7 sw store erases");
    wait_ph(0, "R7 sw store ends");

    // R8 power fail with latch clear
    pulse_pf();
    chk("R8 no store latch clear", int'(phase), 0);
    tick();
    chk("R8 still idle", int'(phase), 0);
    // R8 power fail with latch set
    one_write();
    pulse_pf();
    chk("R8 pf store starts", int'(phase), 1);
    wait_ph(2, "R8 pf store erases");
    pulse_pf();
    // R9 absorbed
    wait_ph(0, "R9 store finishes");
    repeat (4) tick();
    chk("R9 no second store", int'(phase), 0);

    // R10 disable takes effect and blocks pf store
    pulse_dis();
    chk("R10 disabled", int'(auto_en), 0);
    one_write();
    pulse_pf();
    tick();
    chk("R8 no store when disabled", int'(phase), 0);
    power_cycle();
    chk("R10 reload from copy enabled", int'(auto_en), 1);
    pulse_dis();
    pulse_store();
    wait_ph(0, "R10 manual store done");
    power_cycle();
    chk("R10 copy saved disabled", int'(auto_en), 0);
    pulse_ena();
    chk("R10 enabled by cmd", int'(auto_en), 1);

    // R7 software recall
    pulse_recall();
    chk("R7 recall delay", int'(phase), 1);
    chk("R7 recall no pull", int'(pull_low), 0);
    run_len(1, n); chk("R7 recall delay length", n, DLY);
    chk("R7 recall clear", int'(phase), 5);
    chk("R7 clear no pull", int'(pull_low), 0);
    run_len(5, n); chk("R7 clear length", n, CLR);
    run_len(6, n); chk("R7 load length", n, LDC);
    chk("R7 straight to idle", int'(phase), 0);
    chk("R7 no high drive", int'(drv_high), 0);
    chk("R10 recall reloads copy", int'(auto_en), 0);

    // R3 random traffic against gate model
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      host_wr  = 1'($urandom % 2);
      sw_store = ($urandom % 23) == 0;
      ext_low  = ($urandom % 37) == 0;
      pwr_ok   = ($urandom % 50) != 0;
      #1;
      chk("R3 random rd gate", int'(rd_ok), exp_rd(pwr_ok, phase));
      chk("R3 random wr gate", int'(wr_ok), exp_wr(pwr_ok, phase, busy_pin));
      tick();
    end
    host_wr = 0; sw_store = 0; ext_low = 0; pwr_ok = 1;
    wait_ph(0, "R2 settles idle");

    report();
    $finish;
  end
endmodule